// File: doc/BRIEF.md
# Grouped Input Port Edge Interrupt

This block watches eight active-low input pins, split into two groups of four. Software reads each group's synchronized pin levels over a small 4-bit register bus. It also receives a single interrupt line, which is raised when a group becomes active. A group becomes active when its combined level drops, meaning that at least one of its pins goes low while all four pins had been high.

Each group has its own enable bit and its own pending flag. Reading the pending register returns the flags and then clears them. Enabling a group while one of its pins is already held low marks that group pending at once. Software can therefore find a key that is being held down without waiting for a new edge.

Top module: `grouped_key_irq`

## Requirements
- R1: A read of address 0 returns pins_n[3:0], and a read of address 1 returns pins_n[7:4], each after a two-flop synchronizer. A bit reads 1 for a high pin. After reset both addresses read 4'hF until the pins have propagated. Writes to these addresses change nothing.
- R2: When a group is enabled and its four synchronized bits change from all-high to at least one low, that group's pending flag is set.
- R3: Address 2 holds the enable bits: bit 0 for group 0 and bit 1 for group 1, where 1 means enabled. Both reset to 0. A falling edge in a disabled group leaves its flag at 0.
- R4: A read of address 3 returns the pending flags in bit 0 (group 0) and bit 1 (group 1), with bits 3:2 reading 0. Both flags reset to 0. Writes to address 3 have no effect.
- R5: A read of address 3 clears both flags in the same cycle. If a flag is set in the same cycle as that read, the set wins: the read returns the old value and the flag stays 1.
- R6: A write that changes a group's enable bit from 0 to 1 while any pin of that group is low sets that group's flag. Rewriting an enable bit that is already 1 does not set the flag. Enabling a group while all of its pins are high does not set the flag either.
- R7: If one pin of a group goes low while another pin of the same group is already low, no new flag is set.
- R8: irq is 1 exactly when some group has both its flag and its enable bit set. Clearing an enable bit lowers irq but keeps the flag.
- R9: Read data is registered. It appears on bus_rdata in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Registered read data |
| pins_n | input | 8 | Active-low input pins; group g occupies bits 4g+3..4g |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag being set in the same cycle that a read clears the pending register. That case tests the set-wins priority of R5. The stimulus drops a pin on a falling clock edge. It then counts exactly two rising edges through the synchronizer and issues the pending-register read so that the read lands on the edge where the flag is set. A second read then confirms that the flag survived. The enable-while-held case (R6) is reached differently. A pin is held low while its group is disabled, and only then is the group enabled.

// File: rtl/gki_pkg.sv
package gki_pkg;

    localparam int unsigned GKI_GROUPS    = 2;
    localparam int unsigned GKI_GROUP_W   = 4;
    localparam int unsigned GKI_DATA_W    = 4;
    localparam int unsigned GKI_ADDR_W    = 2;
    localparam int unsigned GKI_SYNC_STG  = 2;

    typedef enum logic [1:0] {
        REG_LEVEL = 2'd0,
        REG_MASK  = 2'd1,
        REG_FLAG  = 2'd2,
        REG_NONE  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        reg_kind_e  kind;
    } access_t;

    // Level registers sit at 0..groups-1, then enable, then pending.
    function automatic reg_kind_e gki_classify(input int unsigned addr,
                                               input int unsigned groups);
        if (addr < groups)            return REG_LEVEL;
        else if (addr == groups)      return REG_MASK;
        else if (addr == groups + 1)  return REG_FLAG;
        else                          return REG_NONE;
    endfunction

endpackage

// File: rtl/gki_sync.sv
module gki_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Resets to the inactive (high) level so no edge follows reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gki_group.sv
module gki_group #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level,
    input  logic             mask_en,
    input  logic             mask_rise,
    input  logic             rd_clr,
    output logic             flag,
    output logic             fall_evt,
    output logic             set_evt
);
    logic all_hi;
    logic prev_hi_q;
    logic flag_q;

    assign all_hi   = &level;
    assign fall_evt = prev_hi_q & ~all_hi;
    // Edge path, or the enable-while-held path.
    assign set_evt  = (fall_evt & mask_en) | (mask_rise & ~all_hi);

    always_ff @(posedge clk) begin
        if (rst) prev_hi_q <= 1'b1;
        else     prev_hi_q <= all_hi;
    end

    // Setting beats the read-clear so no event is lost.
    always_ff @(posedge clk) begin
        if (rst)          flag_q <= 1'b0;
        else if (set_evt) flag_q <= 1'b1;
        else if (rd_clr)  flag_q <= 1'b0;
    end

    assign flag = flag_q;
endmodule

// File: rtl/gki_regs.sv
module gki_regs
    import gki_pkg::*;
#(
    parameter int unsigned GROUPS  = GKI_GROUPS,
    parameter int unsigned GROUP_W = GKI_GROUP_W,
    parameter int unsigned DATA_W  = GKI_DATA_W,
    parameter int unsigned ADDR_W  = GKI_ADDR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [GROUPS*GROUP_W-1:0] levels,
    input  logic [GROUPS-1:0]         flags,
    output logic [GROUPS-1:0]         mask,
    output logic [GROUPS-1:0]         mask_rise,
    output logic                      flag_rd,
    output logic [DATA_W-1:0]         bus_rdata
);
    access_t            acc;
    logic [GROUPS-1:0]  mask_q;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;
    logic               unused_wdata;

    always_comb begin
        acc.rd   = bus_sel & ~bus_wr;
        acc.wr   = bus_sel &  bus_wr;
        acc.kind = gki_classify(32'(bus_addr), GROUPS);
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (acc.wr && acc.kind == REG_MASK)
            mask_q <= bus_wdata[GROUPS-1:0];
    end

    assign mask_rise = (acc.wr && acc.kind == REG_MASK)
                     ? (bus_wdata[GROUPS-1:0] & ~mask_q) : '0;
    assign flag_rd   = acc.rd && acc.kind == REG_FLAG;
    assign mask      = mask_q;
    assign unused_wdata = ^bus_wdata;

    always_comb begin
        rd_mux = '0;
        unique case (acc.kind)
            REG_LEVEL: begin
                for (int g = 0; g < int'(GROUPS); g++)
                    if (bus_addr == ADDR_W'(g))
                        rd_mux = DATA_W'(levels[g*GROUP_W +: GROUP_W]);
            end
            REG_MASK:  rd_mux = DATA_W'(mask_q);
            REG_FLAG:  rd_mux = DATA_W'(flags);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (acc.rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/grouped_key_irq.sv
module grouped_key_irq
    import gki_pkg::*;
#(
    parameter int unsigned GROUPS     = GKI_GROUPS,
    parameter int unsigned GROUP_W    = GKI_GROUP_W,
    parameter int unsigned DATA_W     = GKI_DATA_W,
    parameter int unsigned ADDR_W     = GKI_ADDR_W,
    parameter int unsigned SYNC_STAGES = GKI_SYNC_STG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_sel,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    input  logic [GROUPS*GROUP_W-1:0] pins_n,
    output logic                      irq
);
    localparam int unsigned PIN_W = GROUPS * GROUP_W;

    logic [PIN_W-1:0]  lvl_sync;
    logic [GROUPS-1:0] mask_q;
    logic [GROUPS-1:0] mask_rise;
    logic [GROUPS-1:0] flags;
    logic [GROUPS-1:0] fall_evt;
    logic [GROUPS-1:0] set_evt;
    logic              flag_rd;

    gki_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pins_n),
        .q   (lvl_sync)
    );

    gki_regs #(
        .GROUPS(GROUPS), .GROUP_W(GROUP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .levels    (lvl_sync),
        .flags     (flags),
        .mask      (mask_q),
        .mask_rise (mask_rise),
        .flag_rd   (flag_rd),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_grp
        gki_group #(.WIDTH(GROUP_W)) u_grp (
            .clk       (clk),
            .rst       (rst),
            .level     (lvl_sync[g*GROUP_W +: GROUP_W]),
            .mask_en   (mask_q[g]),
            .mask_rise (mask_rise[g]),
            .rd_clr    (flag_rd),
            .flag      (flags[g]),
            .fall_evt  (fall_evt[g]),
            .set_evt   (set_evt[g])
        );
    end

    assign irq = |(flags & mask_q);
endmodule

// File: rtl/gki_chk.sv
module gki_chk #(
    parameter int unsigned GROUPS  = 2,
    parameter int unsigned GROUP_W = 4,
    parameter int unsigned DATA_W  = 4,
    parameter int unsigned ADDR_W  = 2
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DATA_W-1:0]         bus_rdata,
    input logic [GROUPS*GROUP_W-1:0] lvl_sync,
    input logic [GROUPS-1:0]         mask_q,
    input logic [GROUPS-1:0]         mask_rise,
    input logic [GROUPS-1:0]         flags,
    input logic [GROUPS-1:0]         fall_evt,
    input logic [GROUPS-1:0]         set_evt,
    input logic                      flag_rd,
    input logic                      irq
);
    p_read_flags_r4: assert property (@(posedge clk) disable iff (rst)
        flag_rd |=> bus_rdata == DATA_W'($past(flags)));

    p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);

    for (genvar g = 0; g < int'(GROUPS); g++) begin : g_chk
        p_level_read_r1: assert property (@(posedge clk) disable iff (rst)
            (bus_sel && !bus_wr && bus_addr == ADDR_W'(g))
            |=> bus_rdata == DATA_W'($past(lvl_sync[g*GROUP_W +: GROUP_W])));

        p_flag_cause_r2: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[g]) |-> ($past(fall_evt[g] && mask_q[g]) || $past(mask_rise[g])));

        p_flag_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
            $rose(flags[g]) |-> mask_q[g]);

        p_clear_on_read_r5: assert property (@(posedge clk) disable iff (rst)
            (flag_rd && !set_evt[g]) |=> !flags[g]);
    end
endmodule

bind grouped_key_irq gki_chk #(
    .GROUPS(GROUPS), .GROUP_W(GROUP_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .lvl_sync  (lvl_sync),
    .mask_q    (mask_q),
    .mask_rise (mask_rise),
    .flags     (flags),
    .fall_evt  (fall_evt),
    .set_evt   (set_evt),
    .flag_rd   (flag_rd),
    .irq       (irq)
);

// File: tb/tb_grouped_key_irq.sv
`timescale 1ns/1ps
module tb_grouped_key_irq;
    localparam logic [1:0] A_G0 = 2'd0, A_G1 = 2'd1, A_EN = 2'd2, A_PEND = 2'd3;

    typedef struct {
        logic [3:0] data;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [3:0] bus_wdata = '0;
    logic [3:0] bus_rdata;
    logic [7:0] pins_n = 8'hFF;
    logic       irq;

    int   total = 0;
    int   bad = 0;
    bit   pend = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    grouped_key_irq dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_n(pins_n), .irq(irq)
    );

    // Monitor: a read issued at an edge is compared on the next falling edge.
    always @(posedge clk) pend <= bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R9 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                e = sb.pop_front();
                if (bus_rdata !== e.data) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, bus_rdata, e.data);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [3:0] exp, input string tag);
        exp_t e;
        e.data = exp; e.tag = tag;
        sb.push_back(e);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        total++;
        if (irq !== exp) begin
            bad++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total + 1, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // Reset state
        chk_irq(1'b0, "R8 reset");
        rd(A_G0, 4'hF, "R1 reset level g0");
        rd(A_G1, 4'hF, "R1 reset level g1");
        rd(A_EN, 4'h0, "R3 reset enables");
        rd(A_PEND, 4'h0, "R4 reset flags");

        // Level readback, masked edges, ignored writes
        pins_n = 8'h5A; settle();
        rd(A_G0, 4'hA, "R1 level g0");
        rd(A_G1, 4'h5, "R1 level g1");
        wr(A_G0, 4'h0);
        rd(A_G0, 4'hA, "R1 write to level ignored");
        rd(A_PEND, 4'h0, "R3 disabled edges leave flags clear");
        chk_irq(1'b0, "R3 disabled");
        pins_n = 8'hFF; settle();
        wr(A_PEND, 4'hF);
        rd(A_PEND, 4'h0, "R4 write to pending ignored");

        // Enable while all high: no flag
        wr(A_EN, 4'h1);
        rd(A_PEND, 4'h0, "R6 enable with pins high");
        rd(A_EN, 4'h1, "R3 enable readback");

        // Edge sets flag; read clears
        pins_n = 8'hFB; settle();
        chk_irq(1'b1, "R2 edge raises irq");
        rd(A_PEND, 4'h1, "R2 flag g0 set");
        chk_irq(1'b0, "R5 read clears irq");
        rd(A_PEND, 4'h0, "R5 cleared after read");

        // Second pin falling in an active group
        pins_n = 8'hFA; settle();
        rd(A_PEND, 4'h0, "R7 no new edge while group low");
        pins_n = 8'hFF; settle();

        // Enable while held low
        pins_n = 8'h7F; settle();
        rd(A_PEND, 4'h0, "R3 g1 disabled while held");
        wr(A_EN, 4'h3);
        chk_irq(1'b1, "R6 enable while held raises irq");
        rd(A_PEND, 4'h2, "R6 enable while held sets g1");
        wr(A_EN, 4'h3);
        rd(A_PEND, 4'h0, "R6 rewrite of set enable");
        pins_n = 8'hFF; settle();

        // Disabling hides irq but keeps the flag
        pins_n = 8'hFE; settle();
        chk_irq(1'b1, "R2 g0 edge irq");
        wr(A_EN, 4'h0);
        chk_irq(1'b0, "R8 disable hides irq");
        rd(A_PEND, 4'h1, "R8 flag retained when disabled");
        pins_n = 8'hFF; settle();

        // Both groups in the same cycle
        wr(A_EN, 4'h3);
        pins_n = 8'h7E; settle();
        rd(A_PEND, 4'h3, "R2 both groups flagged");
        pins_n = 8'hFF; settle();

        // Set and read-clear in the same cycle: set wins
        pins_n = 8'hBF;
        repeat (2) @(negedge clk);
        rd(A_PEND, 4'h0, "R5 read in set cycle returns old value");
        rd(A_PEND, 4'h2, "R5 set wins over clear");
        rd(A_PEND, 4'h0, "R5 cleared afterwards");

        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule